// File: doc/BRIEF.md
# Burst Read Wait-State Generator

This block paces a synchronous burst read. When a burst starts, it takes the low word-address bits of the start address. It then counts the words as they are delivered. It tells the host, through a ready flag, in which cycles a data word is present. In high-frequency operation the memory needs extra time in two places: at the start of a burst, and each time the word address passes from the last word of a 128-word row into the next row. In those places the block drops ready for a short wait. In low-frequency operation it never waits.

The wait length is one or two clock cycles, chosen by a configuration input. The host samples both configuration inputs only in the cycle a burst starts. A data-valid strobe marks every cycle that carries a word. Chip enable gates both outputs: with chip enable low, no burst is active, ready rests high and no word is flagged.

Top module: `burst_wait_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ready is 1 and dataValid is 0.
- R2: With chipEn at 0, ready is 1 and dataValid is 0. A burst in progress ends, and no word is flagged until a new start.
- R3: A start is burstStart=1 with chipEn=1 at a clock edge. If fastMode=1 at the start, ready is 0 for L cycles beginning at that edge, and the first word follows. L is 1 when waitTwo=0 and 2 when waitTwo=1.
- R4: If fastMode=0 at the start, ready stays 1 for the whole burst, and dataValid is 1 in every cycle from the start edge on.
- R5: The word address begins at burstAddr and rises by one for each delivered word, wrapping modulo 128. In a fast burst, the delivery of a word whose address is 7Fh (all seven bits set) is followed by L cycles with ready 0 before the next word.
- R6: dataValid is 1 exactly in the cycles where chipEn is 1, a burst is active and ready is 1. It is never 1 while ready is 0.
- R7: fastMode and waitTwo are sampled only at a start. Changing them during a burst has no effect on its ready pattern.
- R8: A start during an active burst, including during a wait, restarts the sequence of R3 to R5 from the new burstAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| chipEn | input | 1 | Chip enable, active high |
| burstStart | input | 1 | Starts a burst when sampled with chipEn high |
| burstAddr | input | 7 | Low word-address bits of the burst start address |
| fastMode | input | 1 | 1 when operating above the frequency threshold |
| waitTwo | input | 1 | Wait length select: 0 gives one cycle, 1 gives two |
| ready | output | 1 | 0 while the host must wait for the next word |
| dataValid | output | 1 | 1 in each cycle that carries a data word |

## Verification
The start edge is cycle 0. Both outputs are decoded without a register from the burst state that this edge loads, so the initial wait shows from cycle 0 through cycle L-1. The first word appears in cycle L for a fast burst and in cycle 0 for a slow one. A boundary wait covers the L cycles right after the cycle that delivered word 7Fh. Chip enable acts on the outputs in the same cycle it changes. The bench drives inputs at the falling edge and samples in the falling-edge half of each cycle. It steps an arithmetic word/wait model once per cycle in that same phase.

// File: rtl/burst_wait_pkg.sv
package burst_wait_pkg;

  // Strobes from the control to the address datapath
  typedef struct packed {
    logic loadAddr;  // take a new burst start address
    logic incAddr;   // a word was delivered this cycle
  } addrCtl_t;

  localparam int WAIT_W = 2;

  // Number of wait cycles for the selected configuration
  function automatic logic [WAIT_W-1:0] waitLenOf(input logic twoCycles);
    return twoCycles ? WAIT_W'(2) : WAIT_W'(1);
  endfunction

endpackage

// File: rtl/burst_wait_addr.sv
module burst_wait_addr
  import burst_wait_pkg::*;
#(
  parameter int BOUND_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  addrCtl_t           ctl,
  input  logic [BOUND_W-1:0] startAddr,
  output logic               atEdge
);

  localparam logic [BOUND_W-1:0] LAST_WORD = '1;

  logic [BOUND_W-1:0] wordAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordAddr <= '0;
    else if (ctl.loadAddr) wordAddr <= startAddr;
    else if (ctl.incAddr)  wordAddr <= wordAddr + BOUND_W'(1);
  end

  // Current word is the last one before a boundary crossing
  assign atEdge = (wordAddr == LAST_WORD);

endmodule

// File: rtl/burst_wait_ctrl.sv
module burst_wait_ctrl
  import burst_wait_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     chipEn,
  input  logic     burstStart,
  input  logic     fastMode,
  input  logic     waitTwo,
  input  logic     atEdge,
  output addrCtl_t ctl,
  output logic     ready,
  output logic     dataValid
);

  logic              active;
  logic              fastQ;
  logic              twoQ;
  logic [WAIT_W-1:0] waitCnt;
  logic              startNow;
  logic              waiting;

  assign startNow = chipEn && burstStart;
  assign waiting  = (waitCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      fastQ   <= 1'b0;
      twoQ    <= 1'b0;
      waitCnt <= '0;
    end else if (!chipEn) begin
      active  <= 1'b0;
      waitCnt <= '0;
    end else if (burstStart) begin
      active  <= 1'b1;
      fastQ   <= fastMode;
      twoQ    <= waitTwo;
      waitCnt <= fastMode ? waitLenOf(waitTwo) : '0;
    end else if (active) begin
      if (waiting)              waitCnt <= waitCnt - WAIT_W'(1);
      else if (atEdge && fastQ) waitCnt <= waitLenOf(twoQ);
    end
  end

  always_comb begin
    ctl.loadAddr = startNow;
    ctl.incAddr  = chipEn && !burstStart && active && !waiting;
  end

  assign dataValid = chipEn && active && !waiting;
  assign ready     = !(chipEn && active && waiting);

endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
  import burst_wait_pkg::*;
#(
  parameter int BOUND_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chipEn,
  input  logic               burstStart,
  input  logic [BOUND_W-1:0] burstAddr,
  input  logic               fastMode,
  input  logic               waitTwo,
  output logic               ready,
  output logic               dataValid
);

  addrCtl_t ctl;
  logic     atEdge;

  burst_wait_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipEn    (chipEn),
    .burstStart(burstStart),
    .fastMode  (fastMode),
    .waitTwo   (waitTwo),
    .atEdge    (atEdge),
    .ctl       (ctl),
    .ready     (ready),
    .dataValid (dataValid)
  );

  burst_wait_addr #(.BOUND_W(BOUND_W)) u_addr (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startAddr(burstAddr),
    .atEdge   (atEdge)
  );

endmodule

// File: rtl/burst_wait_gen_chk.sv
module burst_wait_gen_chk #(
  parameter int BOUND_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               chipEn,
  input logic               burstStart,
  input logic [BOUND_W-1:0] burstAddr,
  input logic               fastMode,
  input logic               waitTwo,
  input logic               ready,
  input logic               dataValid
);

  // Observer state built from the ports only
  logic inBurst, slowQ, oneQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBurst <= 1'b0; slowQ <= 1'b0; oneQ <= 1'b0;
    end else if (!chipEn) begin
      inBurst <= 1'b0;
    end else if (burstStart) begin
      inBurst <= 1'b1; slowQ <= !fastMode; oneQ <= !waitTwo;
    end
  end

  // R2: chip enable low forces the idle output levels
  p_idle_outputs_r2: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> (ready && !dataValid));

  // R6: no word is flagged during a wait
  p_valid_needs_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ready);

  // R3: a fast start begins with a wait
  p_fast_start_waits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && burstStart && fastMode) |=> (!ready || !chipEn));

  // R4: a slow burst never waits
  p_slow_no_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && inBurst && slowQ) |-> ready);

  // R5: a one-cycle wait is never extended without a restart
  p_one_cycle_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && inBurst && oneQ && !ready && !burstStart) |=> (ready || !chipEn));

  // R1: first cycle after reset release is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (ready && !dataValid));

  logic unusedChk;
  assign unusedChk = ^burstAddr;

endmodule

bind burst_wait_gen burst_wait_gen_chk #(.BOUND_W(BOUND_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chipEn    (chipEn),
  .burstStart(burstStart),
  .burstAddr (burstAddr),
  .fastMode  (fastMode),
  .waitTwo   (waitTwo),
  .ready     (ready),
  .dataValid (dataValid)
);

// File: tb/burst_wait_gen_bench.sv
`timescale 1ns/1ps
module burst_wait_gen_bench;

  localparam int BW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b0;
  logic burstStart = 1'b0;
  logic [BW-1:0] burstAddr = '0;
  logic fastMode = 1'b0;
  logic waitTwo = 1'b0;
  logic ready, dataValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  burst_wait_gen #(.BOUND_W(BW)) u_burst_wait_gen (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .burstStart(burstStart),
    .burstAddr(burstAddr), .fastMode(fastMode), .waitTwo(waitTwo),
    .ready(ready), .dataValid(dataValid)
  );

  task automatic check(input string req, input logic gotRdy, input logic gotVal,
                       input logic expRdy, input logic expVal);
    checks++;
    if (gotRdy !== expRdy || gotVal !== expVal) begin
      errors++;
      $display("FAIL %s t=%0t ready/dataValid got %b%b exp %b%b",
               req, $time, gotRdy, gotVal, expRdy, expVal);
    end
  endtask

  // Starts a burst and follows it for n cycles. fast/two are the values at
  // the start; the inputs are inverted afterwards to exercise R7.
  task automatic runBurst(input int start, input bit fast, input bit two,
                          input int n, input string req);
    int addr = start;
    int len = two ? 2 : 1;
    int w = fast ? len : 0;
    chipEn = 1'b1; burstStart = 1'b1; burstAddr = BW'(start);
    fastMode = fast; waitTwo = two;
    @(posedge clk); @(negedge clk);
    burstStart = 1'b0; fastMode = !fast; waitTwo = !two;  // R7
    for (int c = 0; c < n; c++) begin
      bit expRdy = (w == 0);
      check(req, ready, dataValid, expRdy, expRdy);
      if (w > 0) w--;
      else begin
        if (fast && (addr % 128) == 127) w = len;  // R5 boundary
        addr++;
      end
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic endBurst();
    chipEn = 1'b0;
    #1;
    check("R2 same cycle", ready, dataValid, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2 idle", ready, dataValid, 1'b1, 1'b0);
  endtask

  initial begin
    // R1 reset state
    #1;
    check("R1 in reset", ready, dataValid, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", ready, dataValid, 1'b1, 1'b0);
    chipEn = 1'b1; #1;
    check("R6 no burst", ready, dataValid, 1'b1, 1'b0);
    @(negedge clk);

    // Sweep start offsets near and away from the boundary, all configs
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int s = 0; s < 10; s++) begin
        int start = (s < 9) ? 119 + s : 64;
        runBurst(start % 128, cfg[1], cfg[0], 300,
                 cfg[1] ? "R3/R5/R6/R7 fast" : "R4/R6/R7 slow");
        endBurst();
      end
    end

    // R8: restarts mid-burst and mid-wait
    runBurst(126, 1'b1, 1'b0, 4, "R8 first");
    runBurst(10, 1'b1, 1'b1, 1, "R8 restart in wait");
    runBurst(125, 1'b1, 1'b1, 12, "R8 restart");
    runBurst(3, 1'b0, 1'b0, 140, "R8 restart slow");
    endBurst();

    // R2: chip enable drop during a wait, burst does not resume
    runBurst(127, 1'b1, 1'b1, 3, "R5 pre-drop");
    endBurst();
    chipEn = 1'b1; #1;
    check("R2 no resume", ready, dataValid, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2 no resume 2", ready, dataValid, 1'b1, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule